// File: doc/BRIEF.md
# SMBus Nonvolatile Array Command Controller

This block sits behind a byte-level SMBus slave front end and interprets the transactions that address an on-chip nonvolatile byte array of 128 pages, each 64 bytes wide. The front end hands it one event per cycle: a start or repeated start together with the direction bit, a received byte, a request for one byte to transmit, or a stop. For every start and every received byte the block answers with an ACK or NACK one cycle later. It drives three kinds of request to a simple memory model: a combinational read at the current pointer, a one-cycle program strobe with write data, and a one-cycle page-erase strobe.

A write transaction carries a command code in the range 80h to 9Fh as the upper address bits, a second byte as the lower eight address bits, and an optional third byte. With two bytes the transaction only moves the pointer. With three bytes it either erases the page around the pointer or programs one byte there, depending on three enable inputs. After a program or erase the block stays busy for a parameterised number of cycles and refuses every start and byte. Read transactions stream bytes from the pointer, which advances after each byte.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: While reset is applied and after it is released, resp_valid, rd_valid, mem_prog and mem_erase are low, and mem_addr is 0.
- R2: In a write transaction the first byte is ACKed only when it lies in 80h..9Fh; any other first byte is NACKed and every later byte of that transaction is NACKed too.
- R3: A command byte followed by a low byte sets the pointer (mem_addr) to {command[4:0], low byte} and raises neither mem_prog nor mem_erase.
- R4: A third byte programs the addressed location (mem_prog pulse, mem_wdata = that byte, ACK) only when write-enable ctrl_en[1] is 1, erase-enable ctrl_en[2] is 0 and the location reads FFh; with ctrl_en = 000 the byte is NACKed and the location keeps its value.
- R5: A program attempt on a location that does not read FFh is NACKed and the stored value is unchanged.
- R6: With ctrl_en[2] = 1 the third byte is ACKed and erases the page mem_addr[12:6] to FFh, whatever its value and whatever the low six address bits are; erase wins over write-enable, and other pages keep their contents.
- R7: For PROG_CYC cycles after a program and ERASE_CYC cycles after an erase, every start and every byte is NACKed.
- R8: A repeated start with the read bit that directly follows a two-byte address set is ACKed only when ctrl_en[0] = 1; a read start after a stop is ACKed whenever the array is not busy.
- R9: In an ACKed read transaction each read request returns, one cycle later on rd_data with rd_valid, the byte at the pointer; the pointer then advances by one and wraps from 1FFFh to 0000h. Requests in a NACKed read are not answered.
- R10: Every start, repeated start and byte event is answered by exactly one resp_valid pulse in the next cycle, with resp_ack = 1 for ACK and 0 for NACK. Event codes on ev_kind: 0 start, 1 repeated start, 2 byte, 3 read request, 4 stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | An event is present this cycle |
| ev_kind | input | 3 | Event code (0 start, 1 repeated start, 2 byte, 3 read request, 4 stop) |
| ev_rnw | input | 1 | Direction bit with a start: 1 read, 0 write |
| ev_data | input | 8 | Received byte for byte events |
| ctrl_en | input | 3 | Enables: bit 0 read after address set, bit 1 program, bit 2 erase |
| resp_valid | output | 1 | Response to a start or byte is present |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rd_valid | output | 1 | Read byte is present |
| rd_data | output | 8 | Byte read from the array |
| mem_addr | output | 13 | Array address (pointer) |
| mem_rdata | input | 8 | Array data at mem_addr, combinational |
| mem_prog | output | 1 | One-cycle program strobe |
| mem_erase | output | 1 | One-cycle page-erase strobe for page mem_addr[12:6] |
| mem_wdata | output | 8 | Data to program |

## Verification
The hardest situations to reach from the ports are the busy window and the repeated start that follows an address set with no stop between. The stimulus overrides the busy times with short values and issues a new start and byte in the cycles right after an accepted program or erase byte, so the refusal is seen before the window closes, and it issues repeated starts both straight after a two-byte address set and in other positions with the read enable in each state. Erase is exercised with an unaligned low byte and both enables set, then read back inside the page and in the next page.

// File: rtl/eec_pkg.sv
package eec_pkg;

  typedef enum logic [2:0] {
    EV_START  = 3'd0,
    EV_RSTART = 3'd1,
    EV_BYTE   = 3'd2,
    EV_RDREQ  = 3'd3,
    EV_STOP   = 3'd4
  } ev_kind_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WR,
    PH_RD,
    PH_DEAD
  } phase_t;

  localparam int CTRL_RD = 0;
  localparam int CTRL_WR = 1;
  localparam int CTRL_ER = 2;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/eec_busy_timer.sv
module eec_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R7: a new operation is only started when the array is idle
  p_load_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R7: the window closes only by counting down, never by a jump
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != 1 && !load) |=> busy);

endmodule

// File: rtl/eec_ptr.sv
module eec_ptr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)
      ptr_d = load_val;
    else if (inc)
      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R9: each delivered byte moves the pointer by exactly one, wrapping
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R3: a load takes the new address
  p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr_q == $past(load_val)));

endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eec_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 6,
  parameter int PROG_CYC  = 5000,
  parameter int ERASE_CYC = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic              ev_rnw,
  input  logic [7:0]        ev_data,
  input  logic [2:0]        ctrl_en,
  output logic              resp_valid,
  output logic              resp_ack,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_prog,
  output logic              mem_erase,
  output logic [7:0]        mem_wdata
);

  localparam int HI_W    = ADDR_W - 8;
  localparam int TAG_W   = 8 - HI_W;
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [7:0]       CMD_BASE = 8'h80;
  localparam logic [TAG_W-1:0] CMD_TAG  = CMD_BASE[7:HI_W];

  // reset: asserted at once, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // state
  phase_t            phase_q, phase_d;
  logic [1:0]        bcnt_q, bcnt_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              resp_v_q, resp_v_d, resp_a_q, resp_a_d;
  logic              rd_v_q, rd_v_d;
  logic [7:0]        rd_q, rd_d, wd_q, wd_d;
  logic              prog_q, prog_d, erase_q, erase_d;

  logic              ptr_ld, ptr_inc;
  logic [ADDR_W-1:0] ptr_ldv, ptr;
  logic              tm_ld, busy;
  logic [CNT_W-1:0]  tm_val;
  logic              rd_ok;

  eec_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (ptr_ld),
    .load_val (ptr_ldv),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  eec_busy_timer #(.CNT_W(CNT_W)) u_busy (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (tm_ld),
    .load_val (tm_val),
    .busy     (busy)
  );

  assign ptr_ldv = {hi_q, ev_data};

  always_comb begin
    phase_d  = phase_q;
    bcnt_d   = bcnt_q;
    hi_d     = hi_q;
    resp_v_d = 1'b0;
    resp_a_d = 1'b0;
    rd_v_d   = 1'b0;
    rd_d     = rd_q;
    wd_d     = wd_q;
    prog_d   = 1'b0;
    erase_d  = 1'b0;
    ptr_ld   = 1'b0;
    ptr_inc  = 1'b0;
    tm_ld    = 1'b0;
    tm_val   = '0;
    rd_ok    = 1'b1;

    if (ev_valid) begin
      case (ev_kind)
        EV_START, EV_RSTART: begin
          resp_v_d = 1'b1;
          bcnt_d   = 2'd0;
          if (busy) begin
            phase_d = PH_DEAD;
          end else if (ev_rnw) begin
            if (ev_kind == EV_RSTART && phase_q == PH_WR && bcnt_q == 2'd2)
              rd_ok = ctrl_en[CTRL_RD];
            resp_a_d = rd_ok;
            phase_d  = rd_ok ? PH_RD : PH_DEAD;
          end else begin
            resp_a_d = 1'b1;
            phase_d  = PH_WR;
          end
        end

        EV_BYTE: begin
          resp_v_d = 1'b1;
          if (phase_q != PH_WR || busy) begin
            phase_d = PH_DEAD;
          end else begin
            case (bcnt_q)
              2'd0: begin
                if (ev_data[7:HI_W] == CMD_TAG) begin
                  hi_d     = ev_data[HI_W-1:0];
                  bcnt_d   = 2'd1;
                  resp_a_d = 1'b1;
                end else begin
                  phase_d = PH_DEAD;
                end
              end
              2'd1: begin
                ptr_ld   = 1'b1;
                bcnt_d   = 2'd2;
                resp_a_d = 1'b1;
              end
              2'd2: begin
                bcnt_d = 2'd3;
                if (ctrl_en[CTRL_ER]) begin
                  erase_d  = 1'b1;
                  tm_ld    = 1'b1;
                  tm_val   = CNT_W'(ERASE_CYC);
                  resp_a_d = 1'b1;
                end else if (ctrl_en[CTRL_WR] && mem_rdata == ERASED_BYTE) begin
                  prog_d   = 1'b1;
                  wd_d     = ev_data;
                  tm_ld    = 1'b1;
                  tm_val   = CNT_W'(PROG_CYC);
                  resp_a_d = 1'b1;
                end else begin
                  phase_d = PH_DEAD;
                end
              end
              default: phase_d = PH_DEAD;
            endcase
          end
        end

        EV_RDREQ: begin
          if (phase_q == PH_RD && !busy) begin
            rd_v_d  = 1'b1;
            rd_d    = mem_rdata;
            ptr_inc = 1'b1;
          end
        end

        EV_STOP: begin
          phase_d = PH_IDLE;
          bcnt_d  = 2'd0;
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      bcnt_q   <= 2'd0;
      hi_q     <= '0;
      resp_v_q <= 1'b0;
      resp_a_q <= 1'b0;
      rd_v_q   <= 1'b0;
      rd_q     <= '0;
      wd_q     <= '0;
      prog_q   <= 1'b0;
      erase_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      bcnt_q   <= bcnt_d;
      hi_q     <= hi_d;
      resp_v_q <= resp_v_d;
      resp_a_q <= resp_a_d;
      rd_v_q   <= rd_v_d;
      rd_q     <= rd_d;
      wd_q     <= wd_d;
      prog_q   <= prog_d;
      erase_q  <= erase_d;
    end
  end

  assign resp_valid = resp_v_q;
  assign resp_ack   = resp_a_q;
  assign rd_valid   = rd_v_q;
  assign rd_data    = rd_q;
  assign mem_addr   = ptr;
  assign mem_prog   = prog_q;
  assign mem_erase  = erase_q;
  assign mem_wdata  = wd_q;

  // R10: a response only follows a start or byte event
  p_resp_after_event_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    resp_valid |-> $past(ev_valid && (ev_kind == EV_START || ev_kind == EV_RSTART
                                      || ev_kind == EV_BYTE)));

  // R9: read data only follows a read request
  p_rd_after_req_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid |-> $past(ev_valid && ev_kind == EV_RDREQ));

  // R5: only an erased location is ever programmed
  p_prog_erased_only_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_prog |-> ($past(mem_rdata) == ERASED_BYTE));

  // R4: programming needs write-enable and no erase-enable
  p_prog_enable_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_prog |-> ($past(ctrl_en[CTRL_WR]) && !$past(ctrl_en[CTRL_ER])));

  // R6: erase needs erase-enable
  p_erase_enable_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_erase |-> $past(ctrl_en[CTRL_ER]));

  // R7: an operation opens the busy window
  p_op_busy_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_prog || mem_erase) |-> busy);

  // R7: nothing is ACKed while busy
  p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (resp_valid && resp_ack) |-> !$past(busy));

  // R3: address setting leaves the array alone
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({mem_prog, mem_erase, rd_valid}));

endmodule

// File: tb/sim_eeprom_cmd_ctrl.sv
module sim_eeprom_cmd_ctrl;
  import eec_pkg::*;

  localparam int PROG_T  = 20;
  localparam int ERASE_T = 50;
  localparam logic [8:0] ACK = 9'h001;
  localparam logic [8:0] NAK = 9'h000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid;
  logic [2:0]  ev_kind;
  logic        ev_rnw;
  logic [7:0]  ev_data;
  logic [2:0]  ctrl_en;
  logic        resp_valid, resp_ack, rd_valid;
  logic [7:0]  rd_data;
  logic [12:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_prog, mem_erase;
  logic [7:0]  mem_wdata;

  always #5 clk = ~clk;

  eeprom_cmd_ctrl #(.PROG_CYC(PROG_T), .ERASE_CYC(ERASE_T)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_rnw(ev_rnw), .ev_data(ev_data), .ctrl_en(ctrl_en),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_prog(mem_prog), .mem_erase(mem_erase), .mem_wdata(mem_wdata)
  );

  int n_chk = 0, n_fail = 0, n_prog = 0, n_erase = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mem[int];

  function automatic logic [7:0] peek(input logic [12:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'hFF;
  endfunction

  // memory model
  initial mem_rdata = 8'hFF;
  always @(posedge clk) begin
    if (mem_prog) begin
      mem[int'(mem_addr)] = mem_wdata;
      n_prog++;
    end
    if (mem_erase) begin
      for (int i = 0; i < 64; i++) mem.delete(int'({mem_addr[12:6], 6'(i)}));
      n_erase++;
    end
    #1 mem_rdata = peek(mem_addr);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic take(input logic [8:0] got);
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R10 unexpected output actual=%0h expected=none", got);
    end else begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s actual=%0h expected=%0h", t, got, e);
      end
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (!done && rst_n) begin
      if (resp_valid) take({8'h00, resp_ack});
      if (rd_valid)   take({1'b1, rd_data});
    end
  end

  task automatic send(input logic [2:0] k, input logic rnw, input logic [7:0] d,
                      input bit expect_out, input logic [8:0] e, input string tag);
    if (expect_out) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_rnw = rnw; ev_data = d;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic st(input logic rnw, input logic [8:0] e, input string tag);
    send(EV_START, rnw, 8'h00, 1'b1, e, tag);
  endtask
  task automatic rst_rd(input logic [8:0] e, input string tag);
    send(EV_RSTART, 1'b1, 8'h00, 1'b1, e, tag);
  endtask
  task automatic by(input logic [7:0] d, input logic [8:0] e, input string tag);
    send(EV_BYTE, 1'b0, d, 1'b1, e, tag);
  endtask
  task automatic rq(input logic [7:0] v, input string tag);
    send(EV_RDREQ, 1'b0, 8'h00, 1'b1, {1'b1, v}, tag);
  endtask
  task automatic sp();
    send(EV_STOP, 1'b0, 8'h00, 1'b0, NAK, "");
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    st(1'b0, ACK, tag); by(hi, ACK, tag); by(lo, ACK, tag); sp();
  endtask
  task automatic read_at(input logic [7:0] hi, input logic [7:0] lo,
                         input logic [7:0] v, input string tag);
    set_addr(hi, lo, tag);
    st(1'b1, ACK, tag); rq(v, tag); sp();
  endtask
  task automatic prog(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d,
                      input logic [8:0] e, input string tag);
    st(1'b0, ACK, tag); by(hi, ACK, tag); by(lo, ACK, tag); by(d, e, tag); sp();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_kind = '0; ev_rnw = 1'b0; ev_data = '0;
    ctrl_en = 3'b000;
    idle(3);
    check(!resp_valid && !rd_valid && !mem_prog && !mem_erase, "R1 in reset",
          {resp_valid, rd_valid, mem_prog, mem_erase}, 0);
    rst_n = 1'b1;
    idle(4);
    check(!resp_valid && !rd_valid && !mem_prog && !mem_erase, "R1 after release",
          {resp_valid, rd_valid, mem_prog, mem_erase}, 0);
    check(mem_addr == 13'h0, "R1 pointer", mem_addr, 0);

    // R3 address set only, plain read start ACKed with read enable off (R8)
    set_addr(8'h85, 8'h10, "R3 address set");
    check(mem_addr == 13'h0510, "R3 pointer value", mem_addr, 13'h0510);
    check(n_prog == 0 && n_erase == 0, "R3 no array op", n_prog + n_erase, 0);
    st(1'b1, ACK, "R8 plain read start");
    rq(8'hFF, "R9 read erased");
    sp();
    check(mem_addr == 13'h0511, "R9 pointer advance", mem_addr, 13'h0511);

    // R4 write refused with enables off
    prog(8'h85, 8'h10, 8'h5A, NAK, "R4 write disabled");
    read_at(8'h85, 8'h10, 8'hFF, "R4 location unchanged");

    // R4 program, then R7 busy refusal
    ctrl_en = 3'b010;
    prog(8'h85, 8'h10, 8'h5A, ACK, "R4 program accepted");
    st(1'b0, NAK, "R7 start while busy");
    by(8'h85, NAK, "R7 byte while busy");
    sp();
    st(1'b1, NAK, "R7 read start while busy");
    rq(8'h00, "R7 unused"); void'(exp_q.pop_back()); void'(tag_q.pop_back());
    sp();
    idle(PROG_T + 5);

    // R8 repeated start read after address set, enable on
    ctrl_en = 3'b011;
    st(1'b0, ACK, "R8 setup"); by(8'h85, ACK, "R8 setup"); by(8'h10, ACK, "R8 setup");
    rst_rd(ACK, "R8 repeated start enabled");
    rq(8'h5A, "R4 programmed value");
    rq(8'hFF, "R9 next location");
    sp();

    // R5 program over programmed location
    ctrl_en = 3'b010;
    prog(8'h85, 8'h10, 8'hA5, NAK, "R5 not erased");
    read_at(8'h85, 8'h10, 8'h5A, "R5 value kept");

    // R8 repeated start read refused with enable off, requests unanswered (R9)
    st(1'b0, ACK, "R8 setup"); by(8'h85, ACK, "R8 setup"); by(8'h10, ACK, "R8 setup");
    rst_rd(NAK, "R8 repeated start disabled");
    send(EV_RDREQ, 1'b0, 8'h00, 1'b0, NAK, "");
    sp();

    // R2 bad command codes
    st(1'b0, ACK, "R2 start"); by(8'h40, NAK, "R2 cmd 40h"); by(8'h10, NAK, "R2 follow byte");
    sp();
    st(1'b0, ACK, "R2 start"); by(8'hA0, NAK, "R2 cmd A0h"); sp();
    st(1'b0, ACK, "R2 start"); by(8'h7F, NAK, "R2 cmd 7Fh"); sp();
    st(1'b0, ACK, "R2 start"); by(8'h9F, ACK, "R2 cmd 9Fh top"); sp();

    // R9 wrap
    prog(8'h80, 8'h00, 8'h77, ACK, "R4 program 0000h");
    idle(PROG_T + 5);
    set_addr(8'h9F, 8'hFF, "R9 set top");
    st(1'b1, ACK, "R9 read start");
    rq(8'hFF, "R9 top byte");
    rq(8'h77, "R9 wrap to 0000h");
    sp();

    // R6 erase
    prog(8'h85, 8'h40, 8'h11, ACK, "R6 next page data");
    idle(PROG_T + 5);
    ctrl_en = 3'b110;
    prog(8'h85, 8'h3F, 8'h00, ACK, "R6 erase accepted");
    st(1'b0, NAK, "R7 start during erase");
    sp();
    idle(ERASE_T + 5);
    check(n_erase == 1, "R6 one erase strobe", n_erase, 1);
    ctrl_en = 3'b000;
    read_at(8'h85, 8'h10, 8'hFF, "R6 page erased");
    read_at(8'h85, 8'h3F, 8'hFF, "R6 erase wins over write");
    read_at(8'h85, 8'h40, 8'h11, "R6 other page kept");
    ctrl_en = 3'b010;
    prog(8'h85, 8'h10, 8'h33, ACK, "R5 reprogram after erase");
    idle(PROG_T + 5);

    idle(4);
    while (exp_q.size() > 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s actual=missing expected=%0h", tag_q.pop_front(), exp_q.pop_front());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule